// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block keeps the 16-bit status word that a command/response remote terminal returns after each message. The word is rebuilt only when the surrounding protocol engine pulses an update strobe. At that moment the block samples four active-low condition inputs from the subsystem. It merges them with the terminal address, the broadcast indication and two conditions it holds itself: a message-error condition and a dynamic-bus-control acceptance.

When the protocol engine asks for the status word, the block drives it on a parallel output and pulls a status-enable strobe low for a fixed number of clocks. It also does three other things:
- It flags receive messages that completed cleanly with a good-block pulse of about half a microsecond.
- It latches a self-test failure indication until the next status transmission begins.
- It tells the transfer logic whether a transmit command may fetch data from the subsystem.

Top module: `rt_status_builder`

## Requirements
- R1: While reset is asserted and after it is released, `stat_word` is 0 and `stat_en_n`, `msg_err_n`, `good_blk_n`, `st_fail_n` are high.
- R2: The condition inputs are sampled only on the clock edge where `status_upd` is 1. A low input sets its bit and a high input clears it: `srq_n`→bit 8, `busy_n`→bit 3, `ssflag_n`→bit 2, `tflag_n`→bit 0. Changes between updates do not alter `stat_word`.
- R3: An update writes `term_addr` into bits 15..11 and `bcast_rx` into bit 4. Bits 9 and 7..5 are always 0.
- R4: `illegal_n` is captured only on the clock where `in_cmd` rises (it was 0 on the previous edge). A captured low sets bit 10 at the following update. A low `illegal_n` while `in_cmd` stays high is ignored. `new_msg` clears the captured value.
- R5: One clock after a `fmt_err` pulse, `msg_err_n` goes low. It stays low until the clock after a `new_msg` pulse. While it is low, an update also sets bit 10.
- R6: An update sets bit 1 only when all of the following hold: `dbc_accept_n` is low, `cmd_tx` is 1, the subaddress `cmd_sa` is 0 or 31, the mode code `cmd_wc` is 0, `bcast_rx` is 0, and no illegal or format error is held.
- R7: `tx_data_ok` is 0 when bit 3 of `stat_word` is set and `cmd_tx` is 1. It is 1 for any receive command.
- R8: When `rx_done` is 1, `good_blk_n` goes low for `GB_LEN` clocks (default 6, which is 0.5 µs at 12 MHz), starting on the next edge. This happens only if all of the following hold: `rx_count_ok` is 1, `cmd_tx` is 0, the subaddress is neither 0 nor 31, and no illegal or format error is held. Otherwise no pulse is produced.
- R9: `selftest_fault` drives `st_fail_n` low on the next edge, and it stays low. A `send_stat` pulse returns it high unless the fault is present on that same edge.
- R10: A `send_stat` pulse holds `stat_en_n` low for `STAT_LEN` clocks (default 2), starting on the next edge, with the current word on `stat_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_addr | input | 5 | Assigned terminal address |
| bcast_rx | input | 1 | Current command was broadcast |
| cmd_tx | input | 1 | Transmit/receive bit of current command (1 = transmit) |
| cmd_sa | input | 5 | Subaddress field of current command |
| cmd_wc | input | 5 | Word count / mode code field of current command |
| in_cmd | input | 1 | High while a command is being serviced |
| illegal_n | input | 1 | Active-low illegal-command marker |
| fmt_err | input | 1 | Pulse: format or word error detected |
| new_msg | input | 1 | Pulse: new protocol sequence begins |
| srq_n | input | 1 | Active-low service request |
| busy_n | input | 1 | Active-low subsystem busy |
| ssflag_n | input | 1 | Active-low subsystem flag |
| tflag_n | input | 1 | Active-low terminal flag |
| dbc_accept_n | input | 1 | Active-low accept of bus control |
| status_upd | input | 1 | Pulse: rebuild the status word |
| send_stat | input | 1 | Pulse: present the status word |
| rx_done | input | 1 | Pulse: receive message finished |
| rx_count_ok | input | 1 | Received word count matched |
| selftest_fault | input | 1 | Self-test fault detected |
| stat_word | output | 16 | Current status word |
| stat_en_n | output | 1 | Low while the status word is presented |
| msg_err_n | output | 1 | Latched active-low message error |
| good_blk_n | output | 1 | Active-low good-block pulse |
| st_fail_n | output | 1 | Latched active-low self-test failure |
| tx_data_ok | output | 1 | Transmit data may be requested |

## Verification
The illegal marker is the hardest condition to reach. It counts only on the single clock where `in_cmd` rises, so the stimulus raises `in_cmd` and lowers `illegal_n` on the same clock. In a separate step it lowers `illegal_n` while `in_cmd` is already high, to show that nothing is captured then. The other hard case is a self-test fault that is still present on the very edge where a status transmission starts. The bench holds `selftest_fault` across a `send_stat` pulse so that the set and clear conditions collide. It then drops the fault and checks that the next transmission clears the indication.

// File: rtl/rtsw_pkg.sv
package rtsw_pkg;
  localparam int SW_W      = 16;
  localparam int ADDR_W    = 5;
  localparam int SA_W      = 5;
  localparam int WC_W      = 5;
  localparam int ADDR_LSB  = 11;
  localparam int ME_BIT    = 10;
  localparam int SRQ_BIT   = 8;
  localparam int BCAST_BIT = 4;
  localparam int BUSY_BIT  = 3;
  localparam int SSF_BIT   = 2;
  localparam int DBC_BIT   = 1;
  localparam int TF_BIT    = 0;
  localparam logic [WC_W-1:0] MC_BUS_CTRL = '0;

  typedef struct packed {
    logic srq;
    logic busy;
    logic ssf;
    logic tf;
  } sub_flags_t;

  function automatic logic sa_is_mode(input logic [SA_W-1:0] sa);
    return (&sa) | (~|sa);
  endfunction
endpackage

// File: rtl/rtsw_pulse.sv
module rtsw_pulse #(
  parameter int LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic out_n
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CW'(LEN);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign out_n = (cnt_q == '0);
endmodule

// File: rtl/rtsw_cmd_track.sv
module rtsw_cmd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_cmd,
  input  logic illegal_n,
  input  logic fmt_err,
  input  logic new_msg,
  output logic illegal_q,
  output logic err_q
);
  logic in_cmd_q;
  logic ill_d, err_d;
  logic cmd_rise;

  assign cmd_rise = in_cmd & ~in_cmd_q;

  always_comb begin
    ill_d = illegal_q;
    if (new_msg)  ill_d = 1'b0;
    if (cmd_rise) ill_d = ~illegal_n;
    err_d = err_q;
    if (new_msg)  err_d = 1'b0;
    if (fmt_err)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd_q  <= 1'b0;
      illegal_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      in_cmd_q  <= in_cmd;
      illegal_q <= ill_d;
      err_q     <= err_d;
    end
  end
endmodule

// File: rtl/rtsw_word.sv
module rtsw_word
  import rtsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [ADDR_W-1:0] addr,
  input  sub_flags_t        flags,
  input  logic              bcast,
  input  logic              msg_err,
  input  logic              dbc_set,
  input  logic              send,
  input  logic              fault,
  output logic [SW_W-1:0]   word,
  output logic              fail_n
);
  logic [SW_W-1:0] word_q, word_d, fresh;
  logic            fail_q, fail_d;

  always_comb begin
    fresh = '0;
    fresh[ADDR_LSB +: ADDR_W] = addr;
    fresh[ME_BIT]    = msg_err;
    fresh[SRQ_BIT]   = flags.srq;
    fresh[BCAST_BIT] = bcast;
    fresh[BUSY_BIT]  = flags.busy;
    fresh[SSF_BIT]   = flags.ssf;
    fresh[DBC_BIT]   = dbc_set;
    fresh[TF_BIT]    = flags.tf;
  end

  always_comb begin
    word_d = word_q;
    if (upd) word_d = fresh;
    fail_d = fail_q;
    if (fault) begin
      fail_d = 1'b1;
    end else if (send) begin
      fail_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      fail_q <= 1'b0;
    end else begin
      word_q <= word_d;
      fail_q <= fail_d;
    end
  end

  assign word   = word_q;
  assign fail_n = ~fail_q;
endmodule

// File: rtl/rt_status_builder.sv
module rt_status_builder
  import rtsw_pkg::*;
#(
  parameter int GB_LEN   = 6,
  parameter int STAT_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] term_addr,
  input  logic              bcast_rx,
  input  logic              cmd_tx,
  input  logic [SA_W-1:0]   cmd_sa,
  input  logic [WC_W-1:0]   cmd_wc,
  input  logic              in_cmd,
  input  logic              illegal_n,
  input  logic              fmt_err,
  input  logic              new_msg,
  input  logic              srq_n,
  input  logic              busy_n,
  input  logic              ssflag_n,
  input  logic              tflag_n,
  input  logic              dbc_accept_n,
  input  logic              status_upd,
  input  logic              send_stat,
  input  logic              rx_done,
  input  logic              rx_count_ok,
  input  logic              selftest_fault,
  output logic [SW_W-1:0]   stat_word,
  output logic              stat_en_n,
  output logic              msg_err_n,
  output logic              good_blk_n,
  output logic              st_fail_n,
  output logic              tx_data_ok
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        illegal_q, err_q;
  logic        mode_cmd, dbc_ok, gb_start;
  sub_flags_t  flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  rtsw_cmd_track u_track (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_cmd    (in_cmd),
    .illegal_n (illegal_n),
    .fmt_err   (fmt_err),
    .new_msg   (new_msg),
    .illegal_q (illegal_q),
    .err_q     (err_q)
  );

  always_comb begin
    flags.srq  = ~srq_n;
    flags.busy = ~busy_n;
    flags.ssf  = ~ssflag_n;
    flags.tf   = ~tflag_n;
    mode_cmd   = sa_is_mode(cmd_sa);
    dbc_ok     = ~dbc_accept_n & cmd_tx & mode_cmd & (cmd_wc == MC_BUS_CTRL)
               & ~bcast_rx & ~illegal_q & ~err_q;
    gb_start   = rx_done & rx_count_ok & ~cmd_tx & ~mode_cmd
               & ~illegal_q & ~err_q;
  end

  rtsw_word u_word (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .upd     (status_upd),
    .addr    (term_addr),
    .flags   (flags),
    .bcast   (bcast_rx),
    .msg_err (err_q | illegal_q),
    .dbc_set (dbc_ok),
    .send    (send_stat),
    .fault   (selftest_fault),
    .word    (stat_word),
    .fail_n  (st_fail_n)
  );

  rtsw_pulse #(.LEN(GB_LEN)) u_gb_pulse (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (gb_start),
    .out_n (good_blk_n)
  );

  rtsw_pulse #(.LEN(STAT_LEN)) u_en_pulse (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (send_stat),
    .out_n (stat_en_n)
  );

  assign msg_err_n  = ~err_q;
  assign tx_data_ok = ~(cmd_tx & stat_word[BUSY_BIT]);
endmodule

// File: rtl/rt_status_builder_chk.sv
module rt_status_builder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  term_addr,
  input logic        bcast_rx,
  input logic        cmd_tx,
  input logic [4:0]  cmd_sa,
  input logic [4:0]  cmd_wc,
  input logic        in_cmd,
  input logic        illegal_n,
  input logic        fmt_err,
  input logic        new_msg,
  input logic        srq_n,
  input logic        busy_n,
  input logic        ssflag_n,
  input logic        tflag_n,
  input logic        dbc_accept_n,
  input logic        status_upd,
  input logic        send_stat,
  input logic        rx_done,
  input logic        rx_count_ok,
  input logic        selftest_fault,
  input logic [15:0] stat_word,
  input logic        stat_en_n,
  input logic        msg_err_n,
  input logic        good_blk_n,
  input logic        st_fail_n,
  input logic        tx_data_ok
);
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !msg_err_n);

  a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_err_n && !new_msg) |=> !msg_err_n);

  a_r2_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !status_upd |=> $stable(stat_word));

  a_r9_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_fault |=> !st_fail_n);

  a_r9_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (send_stat && !selftest_fault) |=> st_fail_n);

  a_r8_gb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(good_blk_n) |-> $past(rx_done));

  a_r10_en_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_en_n) |-> $past(send_stat));
endmodule

bind rt_status_builder rt_status_builder_chk u_chk (.*);

// File: tb/rt_status_builder_bench.sv
module rt_status_builder_bench;
  localparam int GB_LEN   = 6;
  localparam int STAT_LEN = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  term_addr, cmd_sa, cmd_wc;
  logic        bcast_rx, cmd_tx, in_cmd, illegal_n, fmt_err, new_msg;
  logic        srq_n, busy_n, ssflag_n, tflag_n, dbc_accept_n;
  logic        status_upd, send_stat, rx_done, rx_count_ok, selftest_fault;
  logic [15:0] stat_word;
  logic        stat_en_n, msg_err_n, good_blk_n, st_fail_n, tx_data_ok;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_q[$];
  logic        prev_en = 1'b1;
  int          run = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  rt_status_builder #(.GB_LEN(GB_LEN), .STAT_LEN(STAT_LEN)) u_rt_status_builder (
    .clk(clk), .rst_n(rst_n), .term_addr(term_addr), .bcast_rx(bcast_rx),
    .cmd_tx(cmd_tx), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .in_cmd(in_cmd),
    .illegal_n(illegal_n), .fmt_err(fmt_err), .new_msg(new_msg),
    .srq_n(srq_n), .busy_n(busy_n), .ssflag_n(ssflag_n), .tflag_n(tflag_n),
    .dbc_accept_n(dbc_accept_n), .status_upd(status_upd),
    .send_stat(send_stat), .rx_done(rx_done), .rx_count_ok(rx_count_ok),
    .selftest_fault(selftest_fault), .stat_word(stat_word),
    .stat_en_n(stat_en_n), .msg_err_n(msg_err_n), .good_blk_n(good_blk_n),
    .st_fail_n(st_fail_n), .tx_data_ok(tx_data_ok)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [4:0] a, input logic me, input logic srq,
                                     input logic bc, input logic bsy, input logic ssf,
                                     input logic dbc, input logic tf);
    return {a, me, 1'b0, srq, 3'b000, bc, bsy, ssf, dbc, tf};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic update();
    status_upd = 1'b1; tick(); status_upd = 1'b0;
  endtask

  task automatic send(input logic [15:0] exp);
    exp_q.push_back(exp);
    send_stat = 1'b1; tick(); send_stat = 1'b0;
    repeat (STAT_LEN + 1) tick();
  endtask

  task automatic gb_run(input int exp_len, input string tag);
    int lows = 0;
    rx_done = 1'b1; tick(); rx_done = 1'b0;
    for (int i = 0; i < GB_LEN + 3; i++) begin
      if (!good_blk_n) lows++;
      tick();
    end
    check(tag, 16'(lows), 16'(exp_len));
  endtask

  // monitor / scoreboard for presented status words (R10)
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!stat_en_n && prev_en) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected enable", 16'd1, 16'd0);
        end else begin
          check("R10 presented word", stat_word, exp_q.pop_front());
        end
        run = 1;
      end else if (!stat_en_n) begin
        run++;
      end else if (!prev_en) begin
        check("R10 enable length", 16'(run), 16'(STAT_LEN));
      end
      prev_en = stat_en_n;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; term_addr = '0; cmd_sa = 5'd3; cmd_wc = 5'd4; bcast_rx = 0;
    cmd_tx = 0; in_cmd = 0; illegal_n = 1; fmt_err = 0; new_msg = 0;
    srq_n = 1; busy_n = 1; ssflag_n = 1; tflag_n = 1; dbc_accept_n = 1;
    status_upd = 0; send_stat = 0; rx_done = 0; rx_count_ok = 1; selftest_fault = 0;
    repeat (3) tick();
    check("R1 word in reset", stat_word, 16'h0);
    check("R1 strobes in reset", {12'h0, stat_en_n, msg_err_n, good_blk_n, st_fail_n}, 16'hF);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 word after reset", stat_word, 16'h0);
    check("R1 strobes after reset", {12'h0, stat_en_n, msg_err_n, good_blk_n, st_fail_n}, 16'hF);

    // R2/R3 pattern A
    term_addr = 5'h15; srq_n = 0; ssflag_n = 0; cmd_tx = 1;
    update();
    w = mk(5'h15, 0, 1, 0, 0, 1, 0, 0);
    check("R2 R3 pattern A", stat_word, w);
    check("R7 tx not busy", {15'h0, tx_data_ok}, 16'h1);
    send(w);
    // R2: changes without update are ignored
    srq_n = 1; ssflag_n = 1; busy_n = 0; tflag_n = 0; term_addr = 5'h02;
    repeat (3) tick();
    check("R2 no update no change", stat_word, w);
    send(w);
    // pattern B with broadcast
    term_addr = 5'h0A; bcast_rx = 1;
    update();
    w = mk(5'h0A, 0, 0, 1, 1, 0, 0, 1);
    check("R2 R3 pattern B", stat_word, w);
    send(w);
    check("R7 tx while busy", {15'h0, tx_data_ok}, 16'h0);
    cmd_tx = 0; tick();
    check("R7 rx while busy", {15'h0, tx_data_ok}, 16'h1);
    busy_n = 1; tflag_n = 1; bcast_rx = 0; term_addr = 5'h11;

    // R4 illegal capture on rising in_cmd
    in_cmd = 1; illegal_n = 0; tick(); illegal_n = 1;
    update();
    w = mk(5'h11, 1, 0, 0, 0, 0, 0, 0);
    check("R4 illegal sets ME", stat_word, w);
    check("R4 msg_err pin unaffected", {15'h0, msg_err_n}, 16'h1);
    send(w);
    new_msg = 1; tick(); new_msg = 0;
    update();
    w = mk(5'h11, 0, 0, 0, 0, 0, 0, 0);
    check("R4 cleared by new_msg", stat_word, w);
    illegal_n = 0; repeat (2) tick(); illegal_n = 1;
    update();
    check("R4 no rise ignored", stat_word, w);
    in_cmd = 0; tick();

    // R5 format error
    fmt_err = 1; tick(); fmt_err = 0;
    check("R5 msg_err low", {15'h0, msg_err_n}, 16'h0);
    repeat (4) tick();
    check("R5 msg_err held", {15'h0, msg_err_n}, 16'h0);
    update();
    check("R5 ME bit", stat_word, mk(5'h11, 1, 0, 0, 0, 0, 0, 0));
    new_msg = 1; tick(); new_msg = 0;
    check("R5 msg_err cleared", {15'h0, msg_err_n}, 16'h1);

    // R6 dynamic bus control
    cmd_tx = 1; cmd_sa = 5'd0; cmd_wc = 5'd0; dbc_accept_n = 0;
    update();
    check("R6 dbc sa0", stat_word, mk(5'h11, 0, 0, 0, 0, 0, 1, 0));
    cmd_sa = 5'd31; update();
    check("R6 dbc sa31", stat_word, mk(5'h11, 0, 0, 0, 0, 0, 1, 0));
    cmd_wc = 5'd1; update();
    check("R6 other mode code", stat_word, mk(5'h11, 0, 0, 0, 0, 0, 0, 0));
    cmd_wc = 5'd0; cmd_sa = 5'd5; update();
    check("R6 non-mode sa", stat_word, mk(5'h11, 0, 0, 0, 0, 0, 0, 0));
    cmd_sa = 5'd0; dbc_accept_n = 1; update();
    check("R6 not accepted", stat_word, mk(5'h11, 0, 0, 0, 0, 0, 0, 0));
    dbc_accept_n = 0; in_cmd = 1; illegal_n = 0; tick(); illegal_n = 1;
    update();
    check("R6 illegal blocks dbc", stat_word, mk(5'h11, 1, 0, 0, 0, 0, 0, 0));
    new_msg = 1; tick(); new_msg = 0; in_cmd = 0; dbc_accept_n = 1; tick();

    // R8 good block
    cmd_tx = 0; cmd_sa = 5'd3; rx_count_ok = 1;
    gb_run(GB_LEN, "R8 good block length");
    cmd_tx = 1; gb_run(0, "R8 none for transmit");
    cmd_tx = 0; cmd_sa = 5'd31; gb_run(0, "R8 none for mode");
    cmd_sa = 5'd3; rx_count_ok = 0; gb_run(0, "R8 none for bad count");
    rx_count_ok = 1; fmt_err = 1; tick(); fmt_err = 0;
    gb_run(0, "R8 none after error");
    new_msg = 1; tick(); new_msg = 0;
    gb_run(GB_LEN, "R8 good block again");

    // R9 self-test latch
    w = stat_word;
    selftest_fault = 1; tick(); selftest_fault = 0;
    check("R9 fail set", {15'h0, st_fail_n}, 16'h0);
    repeat (3) tick();
    check("R9 fail held", {15'h0, st_fail_n}, 16'h0);
    send(w);
    check("R9 cleared by send", {15'h0, st_fail_n}, 16'h1);
    selftest_fault = 1;
    send(w);
    check("R9 persistent fault", {15'h0, st_fail_n}, 16'h0);
    selftest_fault = 0;
    send(w);
    check("R9 cleared after fault gone", {15'h0, st_fail_n}, 16'h1);

    repeat (4) tick();
    check("R10 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule